// File: doc/BRIEF.md
# SRAM write-window timing monitor

This monitor watches the control, address and data lines of an asynchronous static RAM bus. It samples them on a fast free-running clock, where one clock period stands for one sample tick of fixed length. A write window is open only while three conditions hold at the same time: chip select is low, write enable is low, and at least one byte strobe is low. The window closes when any one of those signals returns high. Every setup rule is measured back from that closing edge, whichever signal caused it.

For each closed window the monitor checks four things: how long the data, the address, the chip select and the byte-strobe pattern had been held. It also checks how long each written address stayed on the bus before it changed. Minimum times are given in picoseconds together with the tick period. They are rounded up to whole ticks. Each rule drives a one-clock pulse and a sticky flag, and a saturating counter reports the number of closed windows. The block is used as a passive checker beside a memory controller, in simulation or on a prototype.

Top module: `sram_wr_timing_mon`

## Requirements
- R1: A window is counted only when chip select, write enable and at least one strobe are all low in the same sample. `win_count` rises by exactly one for each window that closes. Overlaps that lack one of the three conditions are never counted.
- R2: A window closes on the first sample in which any one of chip select, write enable or the strobes (all strobes high) becomes inactive.
- R3: The data run length is the number of consecutive samples with unchanged `din`, up to and including the last open sample. If it is below ceil(9000 ps / tick), 9 at the default tick, flag bit 0 (data) is raised.
- R4: If the address run length, measured the same way, is below ceil(12000 ps / tick), 12 at the default tick, flag bit 1 (address) is raised.
- R5: If chip select has been low for fewer than ceil(12000 ps / tick) samples when the window closes, flag bit 2 (chip select) is raised.
- R6: If the current strobe pattern has been held for fewer than ceil(12000 ps / tick) samples when the window closes, flag bit 3 (strobe) is raised.
- R7: An address counts as written once at least one window has closed on it. When a written address changes after fewer than ceil(20000 ps / tick) samples in total (20 at default), flag bit 4 (cycle) is raised.
- R8: With chip select and write enable held low across several addresses, each strobe-framed word is a separate window and is checked and counted on its own.
- R9: A violation drives its `viol_pulse` bit high for exactly one clock and sets the matching `viol_flag` bit. The flag stays set until reset. Reset clears all flags, pulses and the count. Outputs are visible two clocks after the closing input sample reaches the pins.
- R10: A value that changes inside the setup interval and then returns to its earlier value still counts as a violation. The run length restarts at every change.
- R11: Run-length counters saturate at their maximum. A window held longer than the counter range, for example 261 samples with 8-bit counters, reports no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one period is one tick |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| bs_n | input | NBYTE | Byte strobes, active low, bit i frames byte i |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Write data bus |
| viol_flag | output | 5 | Sticky flags: 0 data, 1 address, 2 chip select, 3 strobe, 4 cycle |
| viol_pulse | output | 5 | One-clock violation pulses, same bit order |
| win_count | output | CNT_W | Saturating count of closed write windows |

## Verification
Suppose a run-length counter restarts late, wraps, or misses a glitch. A setup pulse then appears, or fails to appear, two clocks after the closing sample. The flag bits show the error directly on the next check. A stale record of whether the current address was written shows up as a missing or extra cycle pulse in the clock after the address change. A wrong window-open state shows up as a `win_count` that differs from the number of windows driven, as soon as that window closes.

// File: rtl/sram_wm_pkg.sv
package sram_wm_pkg;
  localparam int NRULE     = 5;
  localparam int RL_DATA   = 0;
  localparam int RL_ADDR   = 1;
  localparam int RL_CE     = 2;
  localparam int RL_BYTE   = 3;
  localparam int RL_CYCLE  = 4;

  function automatic int ticks_ceil(input int span_ps, input int tick_ps);
    return (span_ps + tick_ps - 1) / tick_ps;
  endfunction
endpackage

// File: rtl/sram_wm_age.sv
// Run-length tracker: counts consecutive samples of the held value.
module sram_wm_age #(
  parameter int W = 1,
  parameter int AGE_W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     val,
  output logic [AGE_W-1:0] age,
  output logic             chg
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic [W-1:0] held;

  assign chg = (val != held);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= RST_VAL;
      age  <= '0;
    end else begin
      held <= val;
      if (chg)
        age <= AGE_ONE;
      else if (age != AGE_MAX)
        age <= age + AGE_ONE;
    end
  end

  // R11: a saturated count of an unchanged value stays saturated
  a_r11_age_holds_at_max: assert property (@(posedge clk) disable iff (rst)
    (age == AGE_MAX && !chg) |=> (age == AGE_MAX));
endmodule

// File: rtl/sram_wm_window.sv
// Write-window detector and saturating window counter.
module sram_wm_window #(
  parameter int NBYTE = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic [NBYTE-1:0] bs_n,
  output logic             end_now,
  output logic [CNT_W-1:0] win_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ce_q, we_q;
  logic [NBYTE-1:0] bs_q;
  logic             open_now, open_prev;

  assign open_now  = !ce_n && !we_n && !(&bs_n);
  assign open_prev = !ce_q && !we_q && !(&bs_q);
  assign end_now   = open_prev && !open_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b1;
      we_q      <= 1'b1;
      bs_q      <= '1;
      win_count <= '0;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
      bs_q <= bs_n;
      if (end_now && win_count != CNT_MAX)
        win_count <= win_count + CNT_W'(1);
    end
  end

  // R1: the count moves only by one and only after a window closes
  a_r1_count_steps_on_close: assert property (@(posedge clk) disable iff (rst)
    (win_count != $past(win_count)) |->
      ($past(end_now) && win_count == $past(win_count) + CNT_W'(1)));
endmodule

// File: rtl/sram_wr_timing_mon.sv
module sram_wr_timing_mon
  import sram_wm_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NBYTE   = 2,
  parameter int TICK_PS = 1000,
  parameter int DS_PS   = 9000,
  parameter int AS_PS   = 12000,
  parameter int CS_PS   = 12000,
  parameter int BS_PS   = 12000,
  parameter int WC_PS   = 20000,
  parameter int AGE_W   = 8,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [NBYTE-1:0]  bs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [NRULE-1:0]  viol_flag,
  output logic [NRULE-1:0]  viol_pulse,
  output logic [CNT_W-1:0]  win_count
);
  localparam int T_DS = ticks_ceil(DS_PS, TICK_PS);
  localparam int T_AS = ticks_ceil(AS_PS, TICK_PS);
  localparam int T_CS = ticks_ceil(CS_PS, TICK_PS);
  localparam int T_BS = ticks_ceil(BS_PS, TICK_PS);
  localparam int T_WC = ticks_ceil(WC_PS, TICK_PS);

  // input sample stage
  logic              s_ce_n, s_we_n;
  logic [NBYTE-1:0]  s_bs_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_bs_n <= '1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_bs_n <= bs_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  logic [AGE_W-1:0] age_data, age_addr, age_ce, age_bs;
  logic             data_chg, addr_chg, ce_chg, bs_chg;
  logic             end_now;

  sram_wm_age #(.W(DATA_W), .AGE_W(AGE_W), .RST_VAL('0)) u_age_data (
    .clk(clk), .rst(rst), .val(s_din), .age(age_data), .chg(data_chg));
  sram_wm_age #(.W(ADDR_W), .AGE_W(AGE_W), .RST_VAL('0)) u_age_addr (
    .clk(clk), .rst(rst), .val(s_addr), .age(age_addr), .chg(addr_chg));
  sram_wm_age #(.W(1), .AGE_W(AGE_W), .RST_VAL(1'b1)) u_age_ce (
    .clk(clk), .rst(rst), .val(s_ce_n), .age(age_ce), .chg(ce_chg));
  sram_wm_age #(.W(NBYTE), .AGE_W(AGE_W), .RST_VAL('1)) u_age_bs (
    .clk(clk), .rst(rst), .val(s_bs_n), .age(age_bs), .chg(bs_chg));

  sram_wm_window #(.NBYTE(NBYTE), .CNT_W(CNT_W)) u_window (
    .clk(clk), .rst(rst), .ce_n(s_ce_n), .we_n(s_we_n), .bs_n(s_bs_n),
    .end_now(end_now), .win_count(win_count));

  // address has seen a closed window since it last changed
  logic written;
  always_ff @(posedge clk) begin
    if (rst)           written <= 1'b0;
    else if (addr_chg) written <= 1'b0;
    else if (end_now)  written <= 1'b1;
  end

  logic [NRULE-1:0] hit;
  always_comb begin
    hit           = '0;
    hit[RL_DATA]  = end_now && (int'(age_data) < T_DS);
    hit[RL_ADDR]  = end_now && (int'(age_addr) < T_AS);
    hit[RL_CE]    = end_now && (int'(age_ce)   < T_CS);
    hit[RL_BYTE]  = end_now && (int'(age_bs)   < T_BS);
    hit[RL_CYCLE] = addr_chg && (written || end_now) && (int'(age_addr) < T_WC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag  <= '0;
      viol_pulse <= '0;
    end else begin
      viol_pulse <= hit;
      viol_flag  <= viol_flag | hit;
    end
  end

  // R3: setup pulses only follow a closing window
  a_r3_setup_pulse_after_close: assert property (@(posedge clk) disable iff (rst)
    (|viol_pulse[NRULE-2:0]) |-> $past(end_now));

  // R7: a cycle pulse only follows an address change
  a_r7_cycle_pulse_after_addr_change: assert property (@(posedge clk) disable iff (rst)
    viol_pulse[RL_CYCLE] |-> $past(addr_chg));

  for (genvar gi = 0; gi < NRULE; gi++) begin : g_rule_chk
    // R9: a pulse is always mirrored in its flag
    a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
      viol_pulse[gi] |-> viol_flag[gi]);
    // R9: flags hold until reset
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      viol_flag[gi] |=> viol_flag[gi]);
  end

  logic unused_ok;
  assign unused_ok = ce_chg ^ bs_chg ^ data_chg;
endmodule

// File: tb/sram_wr_timing_mon_tb_top.sv
module sram_wr_timing_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic [1:0]  bs_n = 2'b11;
  logic [15:0] addr = '0;
  logic [15:0] din  = '0;
  logic [4:0]  viol_flag, viol_pulse;
  logic [15:0] win_count;

  int n_chk = 0;
  int n_fail = 0;
  int pcnt [5];
  int psnap [5];
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_wr_timing_mon dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .bs_n(bs_n),
    .addr(addr), .din(din), .viol_flag(viol_flag), .viol_pulse(viol_pulse),
    .win_count(win_count));

  initial for (int i = 0; i < 5; i++) pcnt[i] = 0;

  always @(negedge clk)
    if (!rst)
      for (int i = 0; i < 5; i++) pcnt[i] += int'(viol_pulse[i]);

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic c, input logic w, input logic [1:0] b,
                     input logic [15:0] a, input logic [15:0] d);
    ce_n = c; we_n = w; bs_n = b; addr = a; din = d;
  endtask

  task automatic idle(input int n);
    ce_n = 1'b1; we_n = 1'b1; bs_n = 2'b11;
    ticks(n);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    bus(1'b1, 1'b1, 2'b11, 16'h0000, 16'h0000);
    ticks(3);
    rst = 1'b0;
    ticks(1);
    for (int i = 0; i < 5; i++) psnap[i] = pcnt[i];
  endtask

  task automatic expect_out(input string req, input logic [4:0] ef, input int ec);
    chk(req, "viol_flag", int'(viol_flag), int'(ef));
    chk(req, "win_count", int'(win_count), ec);
    for (int i = 0; i < 5; i++)
      chk(req, $sformatf("pulses rule %0d", i), pcnt[i] - psnap[i], int'(ef[i]));
  endtask

  task automatic t_reset;
    do_reset;
    chk("R9", "reset flags", int'(viol_flag), 0);
    chk("R9", "reset pulses", int'(viol_pulse), 0);
    chk("R1", "reset count", int'(win_count), 0);
  endtask

  // R1 partial overlaps not counted; R2 close by write enable
  task automatic t_overlap;
    do_reset;
    bus(1'b0, 1'b0, 2'b11, 16'h1200, 16'hA5A5); ticks(20);
    idle(5);
    bus(1'b1, 1'b0, 2'b00, 16'h1200, 16'hA5A5); ticks(20);
    idle(5);
    expect_out("R1", 5'b00000, 0);
    bus(1'b0, 1'b0, 2'b00, 16'h1200, 16'hA5A5); ticks(20);
    we_n = 1'b1; ticks(1);
    idle(5);
    expect_out("R2", 5'b00000, 1);
  endtask

  task automatic t_data_setup;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0040, 16'h1111); ticks(20);
    din = 16'h2222; ticks(9);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R3", 5'b00000, 1);
    bus(1'b0, 1'b0, 2'b00, 16'h0040, 16'h2222); ticks(20);
    din = 16'h3333; ticks(8);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R3", 5'b00001, 2);
  endtask

  task automatic t_addr_setup;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0100, 16'h5555); ticks(20);
    addr = 16'h0101; ticks(12);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R4", 5'b00000, 1);
    bus(1'b0, 1'b0, 2'b00, 16'h0101, 16'h5555); ticks(20);
    addr = 16'h0102; ticks(11);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R4", 5'b00010, 2);
  endtask

  // R5 plus R2 close by chip select
  task automatic t_ce_setup;
    do_reset;
    bus(1'b1, 1'b0, 2'b00, 16'h0200, 16'h7777); ticks(20);
    ce_n = 1'b0; ticks(12);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R5", 5'b00000, 1);
    bus(1'b1, 1'b0, 2'b00, 16'h0200, 16'h7777); ticks(20);
    ce_n = 1'b0; ticks(11);
    ce_n = 1'b1; ticks(5);
    idle(5);
    expect_out("R5", 5'b00100, 2);
  endtask

  // R6 plus R2 close by strobes
  task automatic t_byte_setup;
    do_reset;
    bus(1'b0, 1'b0, 2'b11, 16'h0300, 16'h9999); ticks(20);
    bs_n = 2'b01; ticks(12);
    bs_n = 2'b11; ticks(5);
    expect_out("R6", 5'b00000, 1);
    bs_n = 2'b10; ticks(11);
    bs_n = 2'b11; ticks(5);
    idle(5);
    expect_out("R6", 5'b01000, 2);
  endtask

  task automatic t_cycle;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0400, 16'h1234); ticks(14);
    idle(6);
    addr = 16'h0401; ticks(5);
    expect_out("R7", 5'b00000, 1);
    bus(1'b0, 1'b0, 2'b00, 16'h0402, 16'h1234); ticks(14);
    idle(5);
    addr = 16'h0403; ticks(5);
    expect_out("R7", 5'b10000, 2);
  endtask

  task automatic t_b2b;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0500, 16'hAAAA); ticks(15);
    bs_n = 2'b11; ticks(6);
    addr = 16'h0501; din = 16'hBBBB; ticks(2);
    bs_n = 2'b00; ticks(15);
    bs_n = 2'b11; ticks(3);
    idle(5);
    expect_out("R8", 5'b00000, 2);
  endtask

  // R10 glitch, then R9 stickiness and reset clear
  task automatic t_glitch_sticky;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0600, 16'hC0DE); ticks(20);
    din = 16'hDEAD; ticks(3);
    din = 16'hC0DE; ticks(3);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R10", 5'b00001, 1);
    bus(1'b0, 1'b0, 2'b00, 16'h0600, 16'hC0DE); ticks(20);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R9", 5'b00001, 2);
    do_reset;
    expect_out("R9", 5'b00000, 0);
  endtask

  task automatic t_long;
    do_reset;
    bus(1'b0, 1'b0, 2'b00, 16'h0700, 16'h0F0F); ticks(261);
    we_n = 1'b1; ticks(1); idle(5);
    expect_out("R11", 5'b00000, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    ticks(1);
    t_reset;
    t_overlap;
    t_data_setup;
    t_addr_setup;
    t_ce_setup;
    t_byte_setup;
    t_cycle;
    t_b2b;
    t_glitch_sticky;
    t_long;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule